// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block holds a small table of words and finds every entry that agrees with a search argument. Only the bit positions selected by a per-search key take part in the compare. Software-style loading goes through a plain RAM-like write port: a binary address picks one entry, and the entry is stored and marked live. A search compares all live entries against the argument at once. The per-entry results are latched into a pending-hit register in a single clock.

After the capture, the block walks the pending-hit register. It emits one hit per cycle, lowest entry index first, with the entry's index and contents on a valid-qualified output stream. When no pending hits remain, a finished flag rises and stays up until the next search or write. A write, or a fresh search, issued while a walk is in progress abandons that walk.

Top module: `keyed_cam`

## Requirements
- R1: While `rst` is high on a clock edge, every entry becomes not live, `hit_vec` becomes zero, and `rd_vld` and `scan_done` become low.
- R2: A clock edge with `wr_en` high stores `wr_data` in the entry selected by the binary index `wr_addr` (3 bits for the default 8 entries) and marks that entry live; a later search shows the new contents.
- R3: Entry i is a hit when, for every bit position where `srch_key` is 1, the stored bit equals the `srch_arg` bit. Bit positions where the key is 0 are ignored, so an all-ones key compares the whole word and an all-zeros key makes every live entry a hit.
- R4: An entry that has not been written since reset is never a hit, whatever the argument and key.
- R5: A clock edge with `srch_go` high and `wr_en` low loads `hit_vec`, bit i being the hit result of entry i. At that edge `rd_vld` and `scan_done` go low.
- R6: From the edge after the capture, each edge emits the lowest-index pending hit. It drives `rd_vld` high with that entry's index on `rd_idx` and its contents on `rd_word`, and clears that bit of `hit_vec`. Outputs therefore come one per cycle in ascending index order.
- R7: At the first walk edge that finds `hit_vec` empty, `scan_done` rises and `rd_vld` is low. With no hits at all, this happens one edge after the capture. `scan_done` then holds until the next search or write.
- R8: A write during a walk abandons it: at that edge `hit_vec` becomes zero, and `rd_vld` and `scan_done` go low.
- R9: A search during a walk abandons it and starts a new walk from the new capture.
- R10: When `wr_en` and `srch_go` are high on the same edge, the write is performed and the search is dropped: `hit_vec` becomes zero and no walk starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store an entry this cycle |
| wr_addr | input | $clog2(WORDS) | Binary index of the entry to store |
| wr_data | input | WIDTH | Contents to store |
| srch_go | input | 1 | Start a search this cycle |
| srch_arg | input | WIDTH | Search argument |
| srch_key | input | WIDTH | Per-bit compare enable, 1 = compared |
| hit_vec | output | WORDS | Pending hits not yet emitted |
| rd_vld | output | 1 | A hit is presented on rd_idx / rd_word |
| rd_idx | output | $clog2(WORDS) | Index of the presented hit |
| rd_word | output | WIDTH | Contents of the presented hit |
| scan_done | output | 1 | Walk finished, no pending hits |

## Verification
The checker assumes the inputs are quiet during reset and that `wr_en` and `srch_go` are single-cycle commands sampled at the clock edge. It also assumes that a walk is only interrupted by those two commands, so that an emitted index always comes from the previous cycle's pending set. The stimulus drives every command for exactly one cycle, on the falling edge, and returns the controls low. Random data is drawn from a narrow value set, and arguments are copied from stored entries with random keys, so that multi-hit walks are frequent. Directed cases cover the interruptions and the simultaneous write and search.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [WIDTH-1:0]       wdata,
  output logic [WORDS*WIDTH-1:0] words_flat,
  output logic [WORDS-1:0]       live
);
  logic [WIDTH-1:0] mem [WORDS];

  // contents carry no reset; liveness does
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     live <= '0;
    else if (we) live[waddr] <= 1'b1;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_flat
    assign words_flat[i*WIDTH +: WIDTH] = mem[i];
  end
endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16
) (
  input  logic [WORDS*WIDTH-1:0] words_flat,
  input  logic [WORDS-1:0]       live,
  input  logic [WIDTH-1:0]       arg,
  input  logic [WIDTH-1:0]       key,
  output logic [WORDS-1:0]       hits
);
  for (genvar i = 0; i < WORDS; i++) begin : g_cmp
    logic [WIDTH-1:0] diff;
    assign diff    = (words_flat[i*WIDTH +: WIDTH] ^ arg) & key;
    assign hits[i] = live[i] & ~(|diff);
  end
endmodule

// File: rtl/cam_pick.sv
module cam_pick #(
  parameter int WORDS = 8,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [WORDS-1:0] vec,
  output logic             found,
  output logic [AW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end
endmodule

// File: rtl/cam_scan.sv
module cam_scan
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic                   go,
  input  logic [WORDS-1:0]       hits,
  input  logic [WORDS*WIDTH-1:0] words_flat,
  output logic [WORDS-1:0]       hit_vec,
  output logic                   rd_vld,
  output logic [AW-1:0]          rd_idx,
  output logic [WIDTH-1:0]       rd_word,
  output logic                   scan_done
);
  scan_state_e      st;
  logic [WORDS-1:0] match_q;
  logic             found;
  logic [AW-1:0]    pick;
  logic [WORDS-1:0] clr_mask;

  cam_pick #(.WORDS(WORDS)) u_pick (
    .vec   (match_q),
    .found (found),
    .idx   (pick)
  );

  assign clr_mask = found ? (WORDS'(1) << pick) : '0;
  assign hit_vec  = match_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SC_IDLE;
      match_q   <= '0;
      rd_vld    <= 1'b0;
      rd_idx    <= '0;
      rd_word   <= '0;
      scan_done <= 1'b0;
    end else if (we) begin
      st        <= SC_IDLE;
      match_q   <= '0;
      rd_vld    <= 1'b0;
      scan_done <= 1'b0;
    end else if (go) begin
      st        <= SC_RUN;
      match_q   <= hits;
      rd_vld    <= 1'b0;
      scan_done <= 1'b0;
    end else if (st == SC_RUN) begin
      if (found) begin
        rd_vld  <= 1'b1;
        rd_idx  <= pick;
        rd_word <= words_flat[pick*WIDTH +: WIDTH];
        match_q <= match_q & ~clr_mask;
      end else begin
        rd_vld    <= 1'b0;
        scan_done <= 1'b1;
        st        <= SC_IDLE;
      end
    end else begin
      rd_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_cam.sv
module keyed_cam #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             srch_go,
  input  logic [WIDTH-1:0] srch_arg,
  input  logic [WIDTH-1:0] srch_key,
  output logic [WORDS-1:0] hit_vec,
  output logic             rd_vld,
  output logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_word,
  output logic             scan_done
);
  logic [WORDS*WIDTH-1:0] words_flat;
  logic [WORDS-1:0]       live;
  logic [WORDS-1:0]       hits;

  cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk        (clk),
    .rst        (rst),
    .we         (wr_en),
    .waddr      (wr_addr),
    .wdata      (wr_data),
    .words_flat (words_flat),
    .live       (live)
  );

  cam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
    .words_flat (words_flat),
    .live       (live),
    .arg        (srch_arg),
    .key        (srch_key),
    .hits       (hits)
  );

  cam_scan #(.WORDS(WORDS), .WIDTH(WIDTH)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .we         (wr_en),
    .go         (srch_go),
    .hits       (hits),
    .words_flat (words_flat),
    .hit_vec    (hit_vec),
    .rd_vld     (rd_vld),
    .rd_idx     (rd_idx),
    .rd_word    (rd_word),
    .scan_done  (scan_done)
  );
endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             srch_go,
  input logic [WORDS-1:0] hit_vec,
  input logic             rd_vld,
  input logic [AW-1:0]    rd_idx,
  input logic [WIDTH-1:0] rd_word,
  input logic             scan_done
);
  logic [WORDS-1:0] prev_hit;
  logic             prev_vld, prev_we, prev_go;
  logic [AW-1:0]    prev_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_hit <= '0;
      prev_vld <= 1'b0;
      prev_we  <= 1'b0;
      prev_go  <= 1'b0;
      prev_idx <= '0;
    end else begin
      prev_hit <= hit_vec;
      prev_vld <= rd_vld;
      prev_we  <= wr_en;
      prev_go  <= srch_go;
      prev_idx <= rd_idx;
    end
  end

  a_r6_from_pending: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> prev_hit[rd_idx]);

  a_r6_bit_consumed: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ($countones(hit_vec) + 1 == $countones(prev_hit)) && ((hit_vec & ~prev_hit) == '0));

  a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && prev_vld) |-> (rd_idx > prev_idx));

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (!rd_vld && hit_vec == '0));

  a_r8_write_aborts: assert property (@(posedge clk) disable iff (rst)
    prev_we |-> (hit_vec == '0 && !rd_vld && !scan_done));

  a_r5_capture_quiet: assert property (@(posedge clk) disable iff (rst)
    (prev_go && !prev_we) |-> (!rd_vld && !scan_done));
endmodule

bind keyed_cam cam_checker #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .srch_go   (srch_go),
  .hit_vec   (hit_vec),
  .rd_vld    (rd_vld),
  .rd_idx    (rd_idx),
  .rd_word   (rd_word),
  .scan_done (scan_done)
);

// File: tb/sim_keyed_cam.sv
module sim_keyed_cam;
  localparam int WORDS = 8;
  localparam int WIDTH = 16;
  localparam int AW = $clog2(WORDS);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             srch_go = 1'b0;
  logic [WIDTH-1:0] srch_arg = '0;
  logic [WIDTH-1:0] srch_key = '0;
  logic [WORDS-1:0] hit_vec;
  logic             rd_vld;
  logic [AW-1:0]    rd_idx;
  logic [WIDTH-1:0] rd_word;
  logic             scan_done;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [WIDTH-1:0] m_mem [WORDS];
  logic [WORDS-1:0] m_live = '0;

  always #5 clk = ~clk;

  keyed_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .srch_go(srch_go), .srch_arg(srch_arg), .srch_key(srch_key),
    .hit_vec(hit_vec), .rd_vld(rd_vld), .rd_idx(rd_idx), .rd_word(rd_word),
    .scan_done(scan_done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic logic [WORDS-1:0] exp_hits(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
    logic [WORDS-1:0] r = '0;
    for (int i = 0; i < WORDS; i++)
      r[i] = m_live[i] && (((m_mem[i] ^ a) & k) == '0);
    return r;
  endfunction

  task automatic write_word(input int a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_mem[a] = d;
    m_live[a] = 1'b1;
  endtask

  task automatic start_search(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
    @(negedge clk);
    srch_go = 1'b1; srch_arg = a; srch_key = k;
    @(negedge clk);
    srch_go = 1'b0;
  endtask

  // called one negedge after the capturing edge
  task automatic verify_scan(input logic [WORDS-1:0] exp, input string tag);
    check(hit_vec == exp && !rd_vld && !scan_done, {tag, " capture R5"}, hit_vec, exp);
    for (int i = 0; i < WORDS; i++) begin
      if (exp[i]) begin
        @(negedge clk);
        check(rd_vld && rd_idx == AW'(i) && rd_word == m_mem[i], "R6 walk output",
              {rd_vld, 4'(rd_idx), rd_word}, {1'b1, 4'(i), m_mem[i]});
      end
    end
    @(negedge clk);
    check(scan_done && !rd_vld && hit_vec == '0, "R7 finish", {scan_done, rd_vld}, 2'b10);
    @(negedge clk);
    check(scan_done && !rd_vld, "R7 finish held", {scan_done, rd_vld}, 2'b10);
  endtask

  task automatic search(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k, input string tag);
    logic [WORDS-1:0] e;
    e = exp_hits(a, k);
    start_search(a, k);
    verify_scan(e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [WORDS-1:0] e;
    int seed_sink;
    seed_sink = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(hit_vec == '0 && !rd_vld && !scan_done, "R1 reset state", {hit_vec, rd_vld, scan_done}, 0);

    // R4: nothing live after reset, even with all-zeros key
    search(16'h0000, 16'h0000, "R4 empty");

    write_word(0, 16'h1234);
    write_word(1, 16'h12FF);
    write_word(2, 16'hAB34);
    write_word(3, 16'h1234);
    write_word(4, 16'h0000);
    write_word(5, 16'hFFFF);
    write_word(6, 16'h1299);

    search(16'h1234, 16'hFFFF, "R2 R3 full key");
    search(16'h1200, 16'hFF00, "R3 upper byte key");
    search(16'h0034, 16'h00FF, "R3 lower byte key");
    search(16'h5A5A, 16'h0000, "R3 R4 zero key, entry 7 not live");
    search(16'h5555, 16'hFFFF, "R7 no hits");

    // R8: write during walk
    start_search(16'h0000, 16'h0000);
    @(negedge clk);
    check(rd_vld && rd_idx == 0, "R8 walk running", rd_idx, 0);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0;
    m_mem[7] = 16'h1234; m_live[7] = 1'b1;
    check(hit_vec == '0 && !rd_vld && !scan_done, "R8 abort on write", {hit_vec, rd_vld, scan_done}, 0);
    @(negedge clk);
    check(!rd_vld && !scan_done, "R8 stays idle", {rd_vld, scan_done}, 0);
    search(16'h1234, 16'hFFFF, "R2 new entry");

    // R9: search during walk
    start_search(16'h0000, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    check(rd_vld && rd_idx == 1, "R9 walk running", rd_idx, 1);
    e = exp_hits(16'hFFFF, 16'hFFFF);
    srch_go = 1'b1; srch_arg = 16'hFFFF; srch_key = 16'hFFFF;
    @(negedge clk);
    srch_go = 1'b0;
    verify_scan(e, "R9 restart");

    // R10: write and search on the same edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'hABCD;
    srch_go = 1'b1; srch_arg = 16'h0000; srch_key = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0; srch_go = 1'b0;
    m_mem[4] = 16'hABCD;
    check(hit_vec == '0 && !rd_vld && !scan_done, "R10 search dropped", {hit_vec, rd_vld, scan_done}, 0);
    @(negedge clk);
    check(!rd_vld && !scan_done, "R10 no walk", {rd_vld, scan_done}, 0);
    search(16'hABCD, 16'hFFFF, "R10 write done");

    // random phase
    for (int n = 0; n < 60; n++) begin
      if ($urandom % 2 == 0) begin
        write_word(int'($urandom % WORDS), 16'hA500 | WIDTH'($urandom % 8) | (WIDTH'($urandom % 2) << 12));
      end
      begin
        logic [WIDTH-1:0] a, k;
        a = m_mem[$urandom % WORDS];
        k = WIDTH'($urandom);
        if ($urandom % 4 == 0) k = 16'hFFFF;
        search(a, k, "R3 random");
      end
    end

    finish_run();
  end
endmodule